// File: doc/BRIEF.md
# CAN Node Fault Confinement Unit

This block keeps the transmit and receive error counters of a CAN node and derives the node's fault-confinement state from them. The state is one of error active, error passive or bus off. The protocol engine supplies one-cycle event pulses for transmit and receive errors and successes. It also pulses once for every sequence of 11 consecutive recessive bits it observes on the bus.

The unit compares both counters against a programmable warning threshold and raises a warning flag. It emits a one-cycle interrupt event whenever the passive flag or the warning flag changes. On a transmit error that pushes the transmit count past its range, the node goes bus off. The unit then forces the reset-mode bit on its own and holds the node off the bus. Recovery waits until software clears that bit. It then counts recessive sequences and returns the node to error active with both counters cleared.

Software sees the reset-mode bit through a write strobe. While that bit is set, software may load either counter and the warning threshold. The bit is set out of power-on reset.

Top module: `can_fault_guard`

## Requirements
- R1: A transmit error adds 8 to the transmit counter. A successful transmission subtracts 1, and the counter never goes below 0. When a transmit error and a transmit success arrive in the same cycle, the error wins.
- R2: A receive error adds 1 to the receive counter, which saturates at 255. A successful reception subtracts 1, and the counter never goes below 0. When a receive error and a receive success arrive in the same cycle, the error wins.
- R3: `errPassive` is 1 when either counter is above 127 and the node is not bus off. `irqPassive` pulses for one cycle in the cycle where `errPassive` changes value, in either direction.
- R4: `errStatus` is 1 when either counter is greater than or equal to the warning limit. `irqWarning` pulses for one cycle in the cycle where `errStatus` changes value.
- R5: A transmit error taken while the transmit counter is above 247 puts the node bus off. On that entry the transmit counter becomes 128, the receive counter becomes 0 and `resetMode` becomes 1. While the node is bus off, error and success events leave both counters unchanged.
- R6: While `resetMode` is 1, recessive-sequence pulses do not advance bus-off recovery. Once `resetMode` is 0, the 128th recessive-sequence pulse ends bus off and clears both counters. After the 127th pulse the node is still bus off.
- R7: While `listenOnly` is 1 the receive counter holds its value and the transmit counter still counts. While `resetMode` is 1 the receive counter keeps counting.
- R8: Writes to the transmit counter, the receive counter and the warning limit through `wrData` take effect only while `resetMode` is 1. In any other cycle these writes are ignored.
- R9: After reset both counters are 0, the warning limit is 96, `resetMode` is 1 and `busOff` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txErr | input | 1 | Transmit error event pulse |
| txOk | input | 1 | Successful transmission pulse |
| rxErr | input | 1 | Receive error event pulse |
| rxOk | input | 1 | Successful reception pulse |
| recessiveSeq | input | 1 | Pulse per 11 consecutive recessive bits seen |
| listenOnly | input | 1 | Listen-only operating mode |
| modeWrEn | input | 1 | Write strobe for the reset-mode bit |
| modeWrData | input | 1 | Value written to the reset-mode bit |
| tecWrEn | input | 1 | Write strobe for the transmit counter |
| recWrEn | input | 1 | Write strobe for the receive counter |
| limitWrEn | input | 1 | Write strobe for the warning limit |
| wrData | input | 8 | Write data for counters and limit |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| warnLimit | output | 8 | Current warning limit |
| resetMode | output | 1 | Reset-mode bit |
| busOff | output | 1 | Node is bus off |
| errPassive | output | 1 | Node is error passive |
| errStatus | output | 1 | A counter has reached the warning limit |
| irqPassive | output | 1 | Passive-state change event |
| irqWarning | output | 1 | Warning-state change event |

## Verification
The assertions take two things for granted. The event inputs are single-cycle pulses that the protocol engine raises only on clock edges. Each write strobe carries data that is meant for that cycle alone. The bench drives every input half a cycle away from the active edge and clears the inputs after one cycle, so no pulse lasts longer than one cycle. Some cases raise an error and a success in the same cycle. The bench uses these cases on purpose to exercise the error-wins rule, and the assertions do not exclude them.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic countEn;      // node not bus off: events may move counters
    logic wrAllow;      // reset mode: software writes accepted
    logic enterBusOff;  // load bus-off values this cycle
    logic recoverDone;  // recovery finished this cycle
  } fcgStrobe_t;
endpackage

// File: rtl/fcg_datapath.sv
module fcg_datapath
  import fcg_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int TX_ERR_STEP  = 8,
  parameter int WARN_DEFAULT = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  fcgStrobe_t       st,
  input  logic             txErr,
  input  logic             txOk,
  input  logic             rxErr,
  input  logic             rxOk,
  input  logic             listenOnly,
  input  logic             tecWrEn,
  input  logic             recWrEn,
  input  logic             limitWrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [CNT_W-1:0] warnLimit,
  output logic             tecOverflow,
  output logic             errPassive,
  output logic             errStatus,
  output logic             irqPassive,
  output logic             irqWarning
);
  localparam int CNT_MAX    = (1 << CNT_W) - 1;
  localparam int HALF       = 1 << (CNT_W - 1);
  localparam logic [CNT_W-1:0] BUSOFF_TEC = CNT_W'(HALF);
  localparam logic [CNT_W-1:0] OVF_EDGE   = CNT_W'(CNT_MAX - TX_ERR_STEP);
  localparam logic [CNT_W-1:0] PASS_EDGE  = CNT_W'(HALF - 1);

  logic prevPassive, prevWarn;

  assign tecOverflow = tec > OVF_EDGE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tec <= '0;
    end else if (st.enterBusOff) begin
      tec <= BUSOFF_TEC;
    end else if (st.recoverDone) begin
      tec <= '0;
    end else if (st.wrAllow && tecWrEn) begin
      tec <= wrData;
    end else if (st.countEn) begin
      if (txErr)                tec <= tec + CNT_W'(TX_ERR_STEP);
      else if (txOk && tec != 0) tec <= tec - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rec <= '0;
    end else if (st.enterBusOff || st.recoverDone) begin
      rec <= '0;
    end else if (st.wrAllow && recWrEn) begin
      rec <= wrData;
    end else if (st.countEn && !listenOnly) begin
      if (rxErr) begin
        if (rec != CNT_W'(CNT_MAX)) rec <= rec + 1'b1;
      end else if (rxOk && rec != 0) begin
        rec <= rec - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                         warnLimit <= CNT_W'(WARN_DEFAULT);
    else if (st.wrAllow && limitWrEn) warnLimit <= wrData;
  end

  assign errPassive = st.countEn && (tec > PASS_EDGE || rec > PASS_EDGE);
  assign errStatus  = (tec >= warnLimit) || (rec >= warnLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPassive <= 1'b0;
      prevWarn    <= 1'b0;
    end else begin
      prevPassive <= errPassive;
      prevWarn    <= errStatus;
    end
  end

  assign irqPassive = errPassive ^ prevPassive;
  assign irqWarning = errStatus ^ prevWarn;

  // R1: a counted transmit error moves the counter up by the step
  p_tec_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    st.countEn && txErr && !st.enterBusOff && !(st.wrAllow && tecWrEn)
    |=> tec == $past(tec) + CNT_W'(TX_ERR_STEP));

  // R7: listen-only holds the receive counter
  p_rec_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    listenOnly && !st.enterBusOff && !st.recoverDone && !(st.wrAllow && recWrEn)
    |=> $stable(rec));

  // R5: bus-off entry values
  p_busoff_values_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.enterBusOff |=> tec == BUSOFF_TEC && rec == '0);

  // R2: receive counter floor
  p_rec_floor_r2: assert property (@(posedge clk) disable iff (!rstN)
    rec == '0 && !rxErr && !(st.wrAllow && recWrEn) |=> rec == '0);
endmodule

// File: rtl/fcg_ctrl.sv
module fcg_ctrl
  import fcg_pkg::*;
#(
  parameter int RECOVERY_SEQS = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txErr,
  input  logic       tecOverflow,
  input  logic       recessiveSeq,
  input  logic       modeWrEn,
  input  logic       modeWrData,
  output fcgStrobe_t st,
  output logic       resetModeQ,
  output logic       busOffQ
);
  localparam int RCW = $clog2(RECOVERY_SEQS + 1);
  localparam logic [RCW-1:0] LAST_SEQ = RCW'(RECOVERY_SEQS - 1);

  logic [RCW-1:0] seqCnt;
  logic           enterBusOff, recovering, recoverDone;

  assign enterBusOff = txErr && tecOverflow && !busOffQ;
  assign recovering  = busOffQ && !resetModeQ;
  assign recoverDone = recovering && recessiveSeq && seqCnt == LAST_SEQ;

  always_ff @(posedge clk) begin
    if (!rstN)            resetModeQ <= 1'b1;
    else if (enterBusOff) resetModeQ <= 1'b1;
    else if (modeWrEn)    resetModeQ <= modeWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busOffQ <= 1'b0;
    else if (enterBusOff) busOffQ <= 1'b1;
    else if (recoverDone) busOffQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !recovering || recoverDone) seqCnt <= '0;
    else if (recessiveSeq)                   seqCnt <= seqCnt + 1'b1;
  end

  always_comb begin
    st.countEn     = !busOffQ;
    st.wrAllow     = resetModeQ;
    st.enterBusOff = enterBusOff;
    st.recoverDone = recoverDone;
  end

  // R5: bus-off entry sets reset mode on its own
  p_enter_forces_reset_r5: assert property (@(posedge clk) disable iff (!rstN)
    enterBusOff |=> busOffQ && resetModeQ);

  // R6: no recovery while reset mode is held
  p_no_recovery_in_reset_r6: assert property (@(posedge clk) disable iff (!rstN)
    busOffQ && resetModeQ |=> busOffQ);
endmodule

// File: rtl/can_fault_guard.sv
module can_fault_guard
  import fcg_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int TX_ERR_STEP   = 8,
  parameter int WARN_DEFAULT  = 96,
  parameter int RECOVERY_SEQS = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErr,
  input  logic             txOk,
  input  logic             rxErr,
  input  logic             rxOk,
  input  logic             recessiveSeq,
  input  logic             listenOnly,
  input  logic             modeWrEn,
  input  logic             modeWrData,
  input  logic             tecWrEn,
  input  logic             recWrEn,
  input  logic             limitWrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec,
  output logic [CNT_W-1:0] warnLimit,
  output logic             resetMode,
  output logic             busOff,
  output logic             errPassive,
  output logic             errStatus,
  output logic             irqPassive,
  output logic             irqWarning
);
  fcgStrobe_t st;
  logic       tecOverflow;

  fcg_ctrl #(.RECOVERY_SEQS(RECOVERY_SEQS)) uCtrl (
    .clk(clk), .rstN(rstN), .txErr(txErr), .tecOverflow(tecOverflow),
    .recessiveSeq(recessiveSeq), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .st(st), .resetModeQ(resetMode), .busOffQ(busOff)
  );

  fcg_datapath #(.CNT_W(CNT_W), .TX_ERR_STEP(TX_ERR_STEP), .WARN_DEFAULT(WARN_DEFAULT)) uData (
    .clk(clk), .rstN(rstN), .st(st), .txErr(txErr), .txOk(txOk), .rxErr(rxErr),
    .rxOk(rxOk), .listenOnly(listenOnly), .tecWrEn(tecWrEn), .recWrEn(recWrEn),
    .limitWrEn(limitWrEn), .wrData(wrData), .tec(tec), .rec(rec),
    .warnLimit(warnLimit), .tecOverflow(tecOverflow), .errPassive(errPassive),
    .errStatus(errStatus), .irqPassive(irqPassive), .irqWarning(irqWarning)
  );
endmodule

// File: tb/can_fault_guard_test.sv
`timescale 1ns/1ps
module can_fault_guard_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txErr = 0, txOk = 0, rxErr = 0, rxOk = 0, recessiveSeq = 0, listenOnly = 0;
  logic modeWrEn = 0, modeWrData = 0, tecWrEn = 0, recWrEn = 0, limitWrEn = 0;
  logic [7:0] wrData = '0;
  logic [7:0] tec, rec, warnLimit;
  logic resetMode, busOff, errPassive, errStatus, irqPassive, irqWarning;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_fault_guard uut (
    .clk(clk), .rstN(rstN), .txErr(txErr), .txOk(txOk), .rxErr(rxErr), .rxOk(rxOk),
    .recessiveSeq(recessiveSeq), .listenOnly(listenOnly), .modeWrEn(modeWrEn),
    .modeWrData(modeWrData), .tecWrEn(tecWrEn), .recWrEn(recWrEn),
    .limitWrEn(limitWrEn), .wrData(wrData), .tec(tec), .rec(rec),
    .warnLimit(warnLimit), .resetMode(resetMode), .busOff(busOff),
    .errPassive(errPassive), .errStatus(errStatus), .irqPassive(irqPassive),
    .irqWarning(irqWarning)
  );

  // {txErr, txOk, rxErr, rxOk, listenOnly}, expected tec, expected rec
  localparam int NV = 12;
  localparam logic [20:0] VEC [NV] = '{
    {5'b01000, 8'd0,  8'd0},   // R1 floor
    {5'b00010, 8'd0,  8'd0},   // R2 floor
    {5'b10000, 8'd8,  8'd0},
    {5'b10000, 8'd16, 8'd0},
    {5'b01000, 8'd15, 8'd0},
    {5'b00100, 8'd15, 8'd1},   // R7 rec counts in reset mode
    {5'b00110, 8'd15, 8'd2},   // R2 error wins
    {5'b11000, 8'd23, 8'd2},   // R1 error wins
    {5'b00101, 8'd23, 8'd2},   // R7 frozen
    {5'b00011, 8'd23, 8'd2},
    {5'b10001, 8'd31, 8'd2},   // R7 tec still counts
    {5'b00010, 8'd31, 8'd1}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ev(input logic [4:0] e);
    {txErr, txOk, rxErr, rxOk, listenOnly} = e;
    @(negedge clk);
    {txErr, txOk, rxErr, rxOk, listenOnly} = '0;
  endtask

  // sel: 0 tec, 1 rec, 2 limit
  task automatic wr(input int sel, input logic [7:0] d);
    wrData = d;
    tecWrEn = (sel == 0); recWrEn = (sel == 1); limitWrEn = (sel == 2);
    @(negedge clk);
    {tecWrEn, recWrEn, limitWrEn} = '0;
  endtask

  task automatic setMode(input logic m);
    modeWrEn = 1; modeWrData = m;
    @(negedge clk);
    modeWrEn = 0;
  endtask

  task automatic seq(input int n);
    for (int i = 0; i < n; i++) begin
      recessiveSeq = 1;
      @(negedge clk);
      recessiveSeq = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9", "tec", tec, 0);
    chk("R9", "rec", rec, 0);
    chk("R9", "limit", warnLimit, 96);
    chk("R9", "resetMode", resetMode, 1);
    chk("R9", "busOff", busOff, 0);

    for (int v = 0; v < NV; v++) begin
      ev(VEC[v][20:16]);
      chk("R1", "table tec", tec, VEC[v][15:8]);
      chk("R2", "table rec", rec, VEC[v][7:0]);
      chk("R3", "table passive", errPassive, 0);
    end

    // R8 write in reset mode, R4 warning pulse
    wr(0, 8'd120);
    chk("R8", "tec write", tec, 120);
    chk("R4", "errStatus", errStatus, 1);
    chk("R4", "irqWarning", irqWarning, 1);
    wr(1, 8'd5);
    chk("R8", "rec write", rec, 5);
    chk("R4", "irqWarning drop", irqWarning, 0);
    setMode(0);
    chk("R8", "resetMode clr", resetMode, 0);
    wr(0, 8'd7);
    chk("R8", "tec write ignored", tec, 120);
    wr(2, 8'd10);
    chk("R8", "limit write ignored", warnLimit, 96);

    // R3 passive transitions
    ev(5'b10000);
    chk("R3", "tec 128", tec, 128);
    chk("R3", "passive on", errPassive, 1);
    chk("R3", "irqPassive on", irqPassive, 1);
    ev(5'b01000);
    chk("R3", "passive off", errPassive, 0);
    chk("R3", "irqPassive off", irqPassive, 1);
    @(negedge clk);
    chk("R3", "irqPassive single", irqPassive, 0);

    // R4 limit change
    setMode(1);
    wr(2, 8'd200);
    chk("R4", "limit", warnLimit, 200);
    chk("R4", "errStatus off", errStatus, 0);
    chk("R4", "irqWarning", irqWarning, 1);

    // R5 bus off from tec 127
    cnt = 0;
    while (!busOff && cnt < 40) begin
      ev(5'b10000);
      cnt++;
    end
    chk("R5", "errors to bus off", cnt, 17);
    chk("R5", "tec", tec, 128);
    chk("R5", "rec", rec, 0);
    chk("R5", "resetMode", resetMode, 1);
    chk("R3", "not passive when bus off", errPassive, 0);
    ev(5'b00100);
    chk("R5", "rec ignored", rec, 0);
    ev(5'b10000);
    chk("R5", "tec ignored", tec, 128);

    // R6 recovery
    seq(130);
    chk("R6", "held in reset mode", busOff, 1);
    setMode(0);
    seq(127);
    chk("R6", "after 127", busOff, 1);
    seq(1);
    chk("R6", "after 128", busOff, 0);
    chk("R6", "tec cleared", tec, 0);
    chk("R6", "rec cleared", rec, 0);
    chk("R6", "resetMode", resetMode, 0);

    // R2 saturation, R7 counting in reset mode
    setMode(1);
    wr(1, 8'd254);
    ev(5'b00100);
    chk("R2", "rec 255", rec, 255);
    ev(5'b00100);
    chk("R2", "rec saturate", rec, 255);
    chk("R3", "passive by rec", errPassive, 1);
    ev(5'b00010);
    chk("R7", "rec counts in reset mode", rec, 254);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule